// File: doc/BRIEF.md
# Control-Flow Signature Watchdog

This block sits beside a processor and listens passively to the instruction fetch stream on the memory bus. Each basic block of the program, meaning a run of instructions closed by a branch, is folded word by word into a running signature. The compiler places a reference signature word in the stream just ahead of the block's closing branch. When that word is fetched, the block compares it with the signature it has built from the words it saw. A difference means the processor did not execute the block the program intended, and a sticky error flag is raised.

The branch circuitry of the processor reports each resolved branch, taken or not, with a single strobe. That strobe closes the current block and restarts the signature from zero. A branch that arrives before any signature word in its block also counts as a control-flow fault. Two folding functions are offered at run time: a plain XOR of the words, and a 32-bit multiple-input shift register. A counter reports how many signature words have been checked.

Top module: `cfsig_watchdog`

## Requirements
- R1: After reset, err_o is 0 and blk_cnt_o is 0.
- R2: With mode_misr_i = 0 the signature of a block is the XOR of its accumulated words, starting from zero. A signature word equal to that value leaves err_o unchanged.
- R3: With mode_misr_i = 1 each accumulated word w updates the signature s to (s shifted left by one, bit 0 filled with 0) XOR (32'h0040_0007 if bit 31 of s was 1, else 0) XOR w. This is the polynomial x^32+x^22+x^2+x+1.
- R4: A signature word (fetch_vld_i = 1, sig_flag_i = 1) whose value differs from the current signature sets err_o one cycle later.
- R5: err_o stays set until a cycle with err_clr_i = 1 clears it. If a new fault is detected in the same cycle as err_clr_i, err_o stays 1.
- R6: A br_vld_i pulse in a block that has not yet had a signature word sets err_o one cycle later.
- R7: Every br_vld_i pulse resets the signature to zero and forgets any earlier signature word. A fault in one block therefore does not affect the check of the next block.
- R8: Signature words are not folded into the signature. Ordinary words fetched after the block's signature word and before its branch, such as the branch instruction itself, are not folded either.
- R9: blk_cnt_o increments by one for each signature word fetched, whether it matches or not, and wraps modulo 2^CNT_W.
- R10: If br_vld_i and fetch_vld_i are high in the same cycle, the branch closes the old block and the fetched word is the first word of the new block.
- R11: When fetch_vld_i is 0, fetch_word_i and sig_flag_i have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_misr_i | input | 1 | 0 selects XOR folding, 1 selects the shift-register folding |
| fetch_vld_i | input | 1 | An instruction word is on the bus this cycle |
| fetch_word_i | input | DATA_W | Fetched word |
| sig_flag_i | input | 1 | The fetched word is a reference signature |
| br_vld_i | input | 1 | A branch has resolved (taken or not taken) |
| err_clr_i | input | 1 | Clears the sticky error flag |
| err_o | output | 1 | Sticky control-flow error |
| blk_cnt_o | output | CNT_W | Number of signature words checked |

## Verification
The properties assume that mode_misr_i does not change inside a basic block. A mode change in the middle of a block would mix two folding functions, and the checks make no claim about the result. The directed stimulus therefore changes the mode only in the idle cycle that follows a branch. Where a property needs to know that no fault can arise, it also assumes that a clear cycle carries no fetch and no branch. The bench keeps these apart except in the one scenario that deliberately drives a fault together with a clear.

// File: rtl/cfsig_pkg.sv
package cfsig_pkg;

   typedef enum logic {
      SIG_FOLD_XOR  = 1'b0,
      SIG_FOLD_MISR = 1'b1
   } sig_fold_e;

   // Taps below x^32 for x^32+x^22+x^2+x+1
   localparam logic [31:0] MISR32_TAPS = 32'h0040_0007;

endpackage

// File: rtl/cfsig_fold.sv
module cfsig_fold #(
   parameter int          W          = 32,
   parameter logic [W-1:0] TAPS      = W'(cfsig_pkg::MISR32_TAPS),
   parameter bit          ALLOW_MISR = 1'b1
) (
   input  logic [W-1:0] acc_i,
   input  logic [W-1:0] word_i,
   input  logic         mode_i,
   output logic [W-1:0] nxt_o
);
   import cfsig_pkg::*;

   logic [W-1:0] xor_val;
   assign xor_val = acc_i ^ word_i;

   generate
      if (ALLOW_MISR) begin : g_both
         logic [W-1:0] misr_val;
         assign misr_val = {acc_i[W-2:0], 1'b0}
                         ^ (acc_i[W-1] ? TAPS : '0)
                         ^ word_i;
         assign nxt_o = (sig_fold_e'(mode_i) == SIG_FOLD_MISR) ? misr_val : xor_val;
      end else begin : g_xor_only
         logic unused_mode;
         assign unused_mode = mode_i;
         assign nxt_o = xor_val;
      end
   endgenerate

endmodule

// File: rtl/cfsig_track.sv
module cfsig_track #(
   parameter int          W          = 32,
   parameter logic [W-1:0] TAPS      = W'(cfsig_pkg::MISR32_TAPS),
   parameter bit          ALLOW_MISR = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         mode_i,
   input  logic         fetch_vld_i,
   input  logic [W-1:0] word_i,
   input  logic         sig_flag_i,
   input  logic         br_vld_i,
   output logic [W-1:0] acc_o,
   output logic         seen_o,
   output logic         chk_evt_o,
   output logic         chk_bad_o,
   output logic         orphan_br_o
);

   logic [W-1:0] acc_q, acc_d, acc_base, folded;
   logic         seen_q, seen_d, seen_base;

   // a branch closes the old block before this cycle's fetch is applied
   assign acc_base  = br_vld_i ? '0   : acc_q;
   assign seen_base = br_vld_i ? 1'b0 : seen_q;

   cfsig_fold #(.W(W), .TAPS(TAPS), .ALLOW_MISR(ALLOW_MISR)) fold_i (
      .acc_i  (acc_base),
      .word_i (word_i),
      .mode_i (mode_i),
      .nxt_o  (folded)
   );

   always_comb begin
      acc_d  = acc_base;
      seen_d = seen_base;
      if (fetch_vld_i) begin
         if (sig_flag_i) begin
            seen_d = 1'b1;
         end else if (!seen_base) begin
            acc_d = folded;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         acc_q  <= acc_d;
         seen_q <= seen_d;
      end
   end

   assign chk_evt_o   = fetch_vld_i && sig_flag_i;
   assign chk_bad_o   = chk_evt_o && (word_i != acc_base);
   assign orphan_br_o = br_vld_i && !seen_q;
   assign acc_o       = acc_q;
   assign seen_o      = seen_q;

endmodule

// File: rtl/cfsig_flags.sv
module cfsig_flags #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             chk_evt_i,
   input  logic             fault_i,
   input  logic             clr_i,
   output logic             err_o,
   output logic [CNT_W-1:0] cnt_o
);

   logic             err_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         err_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         if (fault_i) begin
            err_q <= 1'b1;
         end else if (clr_i) begin
            err_q <= 1'b0;
         end
         if (chk_evt_i) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign err_o = err_q;
   assign cnt_o = cnt_q;

endmodule

// File: rtl/cfsig_watchdog.sv
module cfsig_watchdog #(
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter bit ALLOW_MISR = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mode_misr_i,
   input  logic              fetch_vld_i,
   input  logic [DATA_W-1:0] fetch_word_i,
   input  logic              sig_flag_i,
   input  logic              br_vld_i,
   input  logic              err_clr_i,
   output logic              err_o,
   output logic [CNT_W-1:0]  blk_cnt_o
);
   import cfsig_pkg::*;

   localparam logic [DATA_W-1:0] TAPS = DATA_W'(MISR32_TAPS);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("cfsig_watchdog: DATA_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("cfsig_watchdog: CNT_W must be at least 1");
      end
      if (ALLOW_MISR && DATA_W != 32) begin : g_bad_poly
         $error("cfsig_watchdog: the fixed polynomial needs DATA_W of 32");
      end
   endgenerate

   logic [DATA_W-1:0] acc;
   logic              sig_seen, chk_evt, chk_bad, orphan_br;

   cfsig_track #(.W(DATA_W), .TAPS(TAPS), .ALLOW_MISR(ALLOW_MISR)) track_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_i      (mode_misr_i),
      .fetch_vld_i (fetch_vld_i),
      .word_i      (fetch_word_i),
      .sig_flag_i  (sig_flag_i),
      .br_vld_i    (br_vld_i),
      .acc_o       (acc),
      .seen_o      (sig_seen),
      .chk_evt_o   (chk_evt),
      .chk_bad_o   (chk_bad),
      .orphan_br_o (orphan_br)
   );

   cfsig_flags #(.CNT_W(CNT_W)) flags_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .chk_evt_i (chk_evt),
      .fault_i   (chk_bad || orphan_br),
      .clr_i     (err_clr_i),
      .err_o     (err_o),
      .cnt_o     (blk_cnt_o)
   );

endmodule

// File: rtl/cfsig_watchdog_chk.sv
module cfsig_watchdog_chk #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              fetch_vld_i,
   input logic [DATA_W-1:0] fetch_word_i,
   input logic              sig_flag_i,
   input logic              br_vld_i,
   input logic              err_clr_i,
   input logic              err_o,
   input logic [CNT_W-1:0]  blk_cnt_o,
   input logic [DATA_W-1:0] acc_i,
   input logic              seen_i
);

   AST_ERR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_o && !err_clr_i) |=> err_o); // R5

   AST_ERR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_clr_i && !fetch_vld_i && !br_vld_i) |=> !err_o); // R5

   AST_SIG_MISMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_vld_i && sig_flag_i && !br_vld_i && (fetch_word_i != acc_i)) |=> err_o); // R4

   AST_ORPHAN_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_vld_i && !seen_i) |=> err_o); // R6

   AST_BRANCH_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_vld_i && !fetch_vld_i) |=> (acc_i == '0 && !seen_i)); // R7

   AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_vld_i && sig_flag_i) |=> (blk_cnt_o == CNT_W'($past(blk_cnt_o) + 1'b1))); // R9

   AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(fetch_vld_i && sig_flag_i) |=> $stable(blk_cnt_o)); // R9

   AST_NO_FETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fetch_vld_i && !br_vld_i) |=> ($stable(acc_i) && $stable(seen_i))); // R11

endmodule

bind cfsig_watchdog cfsig_watchdog_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .fetch_vld_i  (fetch_vld_i),
   .fetch_word_i (fetch_word_i),
   .sig_flag_i   (sig_flag_i),
   .br_vld_i     (br_vld_i),
   .err_clr_i    (err_clr_i),
   .err_o        (err_o),
   .blk_cnt_o    (blk_cnt_o),
   .acc_i        (acc),
   .seen_i       (sig_seen)
);

// File: tb/cfsig_watchdog_tb_top.sv
module cfsig_watchdog_tb_top;

   localparam int W  = 32;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode = 1'b0;
   logic          fv = 1'b0;
   logic [W-1:0]  fw = '0;
   logic          sf = 1'b0;
   logic          bv = 1'b0;
   logic          clr = 1'b0;
   logic          err;
   logic [CW-1:0] cnt;

   int checks = 0;
   int fails  = 0;
   int exp_cnt = 0;
   bit done = 0;

   always #5 clk = ~clk;

   cfsig_watchdog #(.DATA_W(W), .CNT_W(CW), .ALLOW_MISR(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mode_misr_i(mode), .fetch_vld_i(fv),
      .fetch_word_i(fw), .sig_flag_i(sf), .br_vld_i(bv), .err_clr_i(clr),
      .err_o(err), .blk_cnt_o(cnt)
   );

   function automatic logic [31:0] misr(input logic [31:0] s, input logic [31:0] w);
      logic [31:0] t;
      t = s << 1;
      if (s[31]) t = t ^ 32'h0040_0007;
      return t ^ w;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one cycle with the given inputs, then return at the following negedge
   task automatic cyc(input logic f, input logic [31:0] w, input logic s,
                      input logic b, input logic c);
      fv = f; fw = w; sf = s; bv = b; clr = c;
      @(posedge clk);
      @(negedge clk);
      fv = 0; fw = 32'hDEAD_BEEF; sf = 0; bv = 0; clr = 0;
      if (f && s) exp_cnt = (exp_cnt + 1) % (1 << CW);
   endtask

   task automatic word(input logic [31:0] w); cyc(1, w, 0, 0, 0); endtask
   task automatic sig(input logic [31:0] w);  cyc(1, w, 1, 0, 0); endtask
   task automatic br();                        cyc(0, 0, 0, 1, 0); endtask
   task automatic clear();                     cyc(0, 0, 0, 0, 1); endtask

   task automatic t_reset();
      chk("R1 err", {31'b0, err}, 0);
      chk("R1 cnt", {28'b0, cnt}, 0);
   endtask

   task automatic t_xor_ok();
      mode = 0;
      word(32'h1111_0000); word(32'h0F0F_1234); word(32'hA5A5_5A5A);
      sig(32'h1111_0000 ^ 32'h0F0F_1234 ^ 32'hA5A5_5A5A);
      word(32'h7777_7777); // branch instruction after signature: R8
      br();
      chk("R2 xor match no error", {31'b0, err}, 0);
      chk("R9 count after one block", {28'b0, cnt}, exp_cnt);
   endtask

   task automatic t_mismatch_sticky();
      word(32'h0000_00FF); sig(32'h0000_00FE);
      chk("R4 mismatch raises error", {31'b0, err}, 1);
      br(); cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
      chk("R5 error sticky", {31'b0, err}, 1);
      clear();
      chk("R5 clear drops error", {31'b0, err}, 0);
   endtask

   task automatic t_misr();
      logic [31:0] s;
      cyc(0, 0, 0, 0, 0);
      mode = 1;
      s = misr(32'h0, 32'h8000_0001);
      s = misr(s, 32'h1234_5678);
      s = misr(s, 32'hFFFF_0000);
      s = misr(s, 32'h0000_0003);
      word(32'h8000_0001); word(32'h1234_5678); word(32'hFFFF_0000); word(32'h0000_0003);
      sig(s); br();
      chk("R3 misr match no error", {31'b0, err}, 0);
      // XOR of the same words must not pass in shift-register mode
      word(32'h8000_0001); word(32'h1234_5678); word(32'hFFFF_0000); word(32'h0000_0003);
      sig(32'h8000_0001 ^ 32'h1234_5678 ^ 32'hFFFF_0000 ^ 32'h0000_0003); br();
      chk("R3 xor value rejected in misr mode", {31'b0, err}, 1);
      clear();
      cyc(0, 0, 0, 0, 0);
      mode = 0;
   endtask

   task automatic t_orphan();
      word(32'h4444_4444); br();
      chk("R6 branch without signature", {31'b0, err}, 1);
      clear();
      chk("R6 cleared", {31'b0, err}, 0);
   endtask

   task automatic t_block_restart();
      word(32'h0BAD_0BAD); br(); // orphan block with leftover signature
      clear();
      word(32'h0000_1357); sig(32'h0000_1357); br();
      chk("R7 next block starts from zero", {31'b0, err}, 0);
      word(32'h2222_0000); sig(32'h2222_0000); sig(32'h2222_0000); br();
      chk("R8 signature word not folded", {31'b0, err}, 0);
   endtask

   task automatic t_no_valid();
      word(32'h0000_00A0);
      cyc(0, 32'hFFFF_FFFF, 0, 0, 0);
      cyc(0, 32'h0000_00A0, 1, 0, 0); // flagged but not valid: no compare
      word(32'h0000_000B);
      chk("R11 invalid cycle no count", {28'b0, cnt}, exp_cnt);
      sig(32'h0000_00AB); br();
      chk("R11 invalid words ignored", {31'b0, err}, 0);
   endtask

   task automatic t_same_cycle();
      word(32'h0000_0011); sig(32'h0000_0011);
      cyc(1, 32'h5555_0000, 0, 1, 0); // branch closes, word opens next block
      word(32'h0000_0101);
      sig(32'h5555_0101); br();
      chk("R10 same-cycle word belongs to new block", {31'b0, err}, 0);
   endtask

   task automatic t_set_beats_clear();
      word(32'h1);
      cyc(1, 32'h2, 1, 0, 1); // mismatch and clear together
      chk("R5 fault wins over clear", {31'b0, err}, 1);
      br(); clear();
      chk("R5 cleared after", {31'b0, err}, 0);
   endtask

   task automatic t_wrap();
      for (int i = 0; i < 20; i++) begin
         word(i); sig(i); br();
      end
      chk("R9 count wraps", {28'b0, cnt}, exp_cnt);
      chk("R9 no error on wrap run", {31'b0, err}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_xor_ok();
      t_mismatch_sticky();
      t_misr();
      t_orphan();
      t_block_restart();
      t_no_valid();
      t_same_cycle();
      t_set_beats_clear();
      t_wrap();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule